// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss by fetching one entry from a flat page table kept in memory. A requester presents a virtual address together with the base address of the current page table. The walker splits off the virtual page number and multiplies it by the entry size. It adds the product to the base, which gives the entry address, and it issues one read on a request/response memory port.

When the entry returns, the walker decodes it. A valid entry yields a physical address, made of the frame number followed by the untouched 4 KB page offset, and a fill record for the translation cache. The fill record carries the page number, the frame number and the read/write/execute permissions. An entry whose valid bit is clear yields a page fault and no fill. The walker serves one walk at a time and reports `busy` for the whole walk.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `resp_valid` and `fill_valid` are all low.
- R2: A request is taken only on a clock edge where `req_valid` is high and `busy` is low. A request presented while `busy` is high has no effect on the memory address issued or on the response of the walk in progress.
- R3: The entry address is `req_base + vpn * ENTRY_BYTES`, computed modulo 2^PA_W, where `vpn` is `req_vaddr[VA_W-1:12]`.
- R4: Each walk issues exactly one memory read. `mem_req_valid` is high for exactly one cycle, which is the first cycle after acceptance.
- R5: The walker waits any number of cycles for `mem_rsp_valid`. `resp_valid` is high for exactly one cycle, in the cycle after the edge at which `mem_rsp_valid` was sampled high.
- R6: For a valid entry, `resp_paddr` is the frame number concatenated with `req_vaddr[11:0]`.
- R7: The entry layout is as follows: bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute, and the frame number occupies bits 12 upward (PA_W-12 bits). `fill_perm` is {x,w,r} and `fill_pfn` is the frame field.
- R8: If entry bit 0 is clear, `resp_fault` is high, `fill_valid` is low and `resp_paddr` is zero. Otherwise `resp_fault` is low and `fill_valid` equals `resp_valid`.
- R9: `busy` is high from the cycle after acceptance through the response cycle, and it is low in the cycle after the response.
- R10: `fill_vpn` equals the page number of the accepted request during the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_base | input | PA_W | Page table base address |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | PA_W | Entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8*ENTRY_BYTES | Page table entry |
| resp_valid | output | 1 | Walk result valid |
| resp_fault | output | 1 | Page fault |
| resp_paddr | output | PA_W | Physical address |
| fill_valid | output | 1 | Fill record valid |
| fill_vpn | output | VA_W-12 | Fill page number |
| fill_pfn | output | PA_W-12 | Fill frame number |
| fill_perm | output | 3 | Fill permissions {x,w,r} |

## Verification
The bench builds the walker with its defaults: 32-bit virtual and physical addresses and 8-byte entries. With those values a 20-bit frame field covers the whole physical space, and a high base register lets the entry address wrap past 2^32. Memory latency ranges from zero to several cycles, so the response can arrive on the cycle right after the request or long after it. Extra requests presented during a walk show whether the walker holds the accepted address.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int ENTRY_BYTES = 8,
  localparam int OFF_W = 12,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int DATA_W = ENTRY_BYTES * 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   req_base,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic [2:0]        fill_perm
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_RESP} state_t;

  state_t            state;
  logic              sent;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   base_q;
  logic              ok_q;
  logic [2:0]        perm_q;
  logic [PFN_W-1:0]  pfn_q;
  logic [VPN_W-1:0]  vpn;

  assign vpn = va_q[VA_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sent   <= 1'b0;
      va_q   <= '0;
      base_q <= '0;
      ok_q   <= 1'b0;
      perm_q <= '0;
      pfn_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= req_base;
          sent   <= 1'b0;
          state  <= S_READ;
        end
        S_READ: begin
          sent <= 1'b1;
          if (mem_rsp_valid) begin
            ok_q   <= mem_rsp_data[0];
            perm_q <= mem_rsp_data[3:1];
            pfn_q  <= mem_rsp_data[OFF_W +: PFN_W];
            state  <= S_RESP;
          end
        end
        S_RESP: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy          = state != S_IDLE;
  assign mem_req_valid = state == S_READ && !sent;
  assign mem_req_addr  = base_q + PA_W'(vpn) * PA_W'(ENTRY_BYTES);
  assign resp_valid    = state == S_RESP;
  assign resp_fault    = resp_valid && !ok_q;
  assign fill_valid    = resp_valid && ok_q;
  assign resp_paddr    = fill_valid ? {pfn_q, va_q[OFF_W-1:0]} : '0;
  assign fill_vpn      = vpn;
  assign fill_pfn      = pfn_q;
  assign fill_perm     = perm_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
)(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_rsp_valid,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic            fill_valid,
  input logic [PA_W-1:0] resp_paddr
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_read_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_req_valid);

  p_read_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_resp_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(mem_rsp_valid));

  p_resp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && !busy);

  p_fault_no_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> !fill_valid && resp_paddr == '0);

  p_busy_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || resp_valid) |-> busy);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .resp_valid(resp_valid), .resp_fault(resp_fault),
  .fill_valid(fill_valid), .resp_paddr(resp_paddr)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int VA_W = 32;
  localparam int PA_W = 32;
  localparam int EB   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base = '0;
  logic busy, mem_req_valid, resp_valid, resp_fault, fill_valid;
  logic [31:0] mem_req_addr, resp_paddr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [19:0] fill_vpn, fill_pfn;
  logic [2:0] fill_perm;

  always #4 clk = ~clk;

  pt_walker #(.VA_W(VA_W), .PA_W(PA_W), .ENTRY_BYTES(EB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_base(req_base), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int mem_reqs = 0;
  int lat_cfg = 0;
  logic [31:0] last_addr = '0;
  logic [63:0] mem_tab [logic [31:0]];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_entry(input bit v, input bit r, input bit w, input bit x,
                                            input logic [19:0] pfn);
    return (64'(pfn) << 12) | (64'(x) << 3) | (64'(w) << 2) | (64'(r) << 1) | 64'(v);
  endfunction

  // behavioural reference: phase 0 idle, 1 reading, 2 responding
  int m_phase = 0;
  bit m_sent = 0;
  logic [31:0] m_va = '0, m_base = '0;
  logic [63:0] m_entry = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_sent = 0;
    end else if (m_phase == 0) begin
      if (req_valid) begin m_phase = 1; m_sent = 0; m_va = req_vaddr; m_base = req_base; end
    end else if (m_phase == 1) begin
      m_sent = 1;
      if (mem_rsp_valid) begin m_entry = mem_rsp_data; m_phase = 2; end
    end else begin
      m_phase = 0;
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic ok;
      logic [31:0] exp_addr;
      ok = m_entry[0];
      exp_addr = m_base + {12'h0, m_va[31:12]} * 32'(EB);
      check("R9", "busy", busy, m_phase != 0);
      check("R4", "mem_req_valid", mem_req_valid, m_phase == 1 && !m_sent);
      if (mem_req_valid) check("R3", "mem_req_addr", mem_req_addr, exp_addr);
      check("R5", "resp_valid", resp_valid, m_phase == 2);
      if (resp_valid) begin
        check("R8", "resp_fault", resp_fault, !ok);
        check("R8", "fill_valid", fill_valid, ok);
        check("R6", "resp_paddr", resp_paddr, ok ? {m_entry[31:12], m_va[11:0]} : 32'h0);
        if (ok) begin
          check("R7", "fill_pfn", fill_pfn, m_entry[31:12]);
          check("R7", "fill_perm", fill_perm, m_entry[3:1]);
        end
        check("R10", "fill_vpn", fill_vpn, m_va[31:12]);
      end
    end
  end

  // memory responder
  bit pend = 0;
  int cnt = 0;
  logic [31:0] paddr_q = '0;
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_tab.exists(paddr_q) ? mem_tab[paddr_q] : 64'h0;
        pend = 0;
      end else cnt--;
    end
    if (mem_req_valid) begin
      pend = 1; cnt = lat_cfg; paddr_q = mem_req_addr; last_addr = mem_req_addr; mem_reqs++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int lat,
                      input int pokes);
    int start_reqs;
    logic [31:0] ea;
    logic [63:0] ent;
    bit ok;
    while (busy) @(negedge clk);
    lat_cfg = lat;
    start_reqs = mem_reqs;
    ea = base + {12'h0, va[31:12]} * 32'(EB);
    ent = mem_tab.exists(ea) ? mem_tab[ea] : 64'h0;
    ok = ent[0];
    req_valid = 1'b1; req_vaddr = va; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < pokes; i++) begin
      req_valid = 1'b1; req_vaddr = ~va; req_base = base + 32'h40;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    check("R3", "entry address", last_addr, ea);
    check("R4", "reads per walk", mem_reqs - start_reqs, 1);
    check("R8", "fault", resp_fault, !ok);
    check("R6", "paddr", resp_paddr, ok ? {ent[31:12], va[11:0]} : 32'h0);
    check("R10", "vpn", fill_vpn, va[31:12]);
    if (ok) check("R7", "perm", fill_perm, ent[3:1]);
    if (pokes > 0) check("R2", "address kept under extra requests", resp_paddr, ok ? {ent[31:12], va[11:0]} : 32'h0);
    @(negedge clk);
    check("R9", "busy after response", busy, 0);
  endtask

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    check("R1", "busy at reset", busy, 0);
    check("R1", "mem_req at reset", mem_req_valid, 0);
    check("R1", "resp at reset", resp_valid, 0);
    check("R1", "fill at reset", fill_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    mem_tab[32'h1018] = mk_entry(1, 1, 0, 0, 20'h7);
    walk(32'h0000_3004, 32'h1000, 0, 0);
    mem_tab[32'h1000 + 32'h45 * 8] = mk_entry(1, 1, 1, 1, 20'hABCDE);
    walk(32'h0004_5FFF, 32'h1000, 5, 0);
    walk(32'h0009_9000, 32'h1000, 2, 0);
    mem_tab[32'h1000 + 32'h12 * 8] = mk_entry(0, 1, 1, 0, 20'h55555);
    walk(32'h0001_2123, 32'h1000, 1, 0);
    mem_tab[32'h0000_0018] = mk_entry(1, 0, 1, 0, 20'hFFFFF);
    walk(32'h0000_5ABC, 32'hFFFF_FFF0, 3, 0);
    mem_tab[32'h2000 + 32'h321 * 8] = mk_entry(1, 0, 0, 1, 20'h00123);
    walk(32'h0032_1777, 32'h2000, 6, 4);
    walk(32'h0032_1000, 32'h2000, 0, 1);

    lcg = 32'h1234_5678;
    for (int n = 0; n < 24; n++) begin
      logic [31:0] va;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      va = {12'h000, lcg[27:20], lcg[11:0]};
      if (n % 3 != 0)
        mem_tab[32'h8000 + {12'h0, va[31:12]} * 8] =
          mk_entry(1, lcg[0], lcg[1], lcg[2], lcg[31:12]);
      walk(va, 32'h8000, n % 4, n % 2);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule